// File: doc/BRIEF.md
# Microword-Steered Accumulator ALU

This block is the arithmetic and register core of a small accumulator-style 8-bit processor. It holds the accumulator, the two index registers and the stack pointer. On every cycle it forms one result byte from a set of decoded microword fields. A four-bit operation code picks one of sixteen functions, grouped as transfer, logic, add/subtract, shift/rotate, bit-test and compare. A two-bit field picks the Q operand. A one-bit field picks the R operand.

All adder-based functions use a single adder. The adder is steered by a subtract-mode bit, which inverts R, and by a carry-source bit. The carry-source bit takes the carry-in either from the external carry flag or from the subtract-mode bit itself. With these two bits the same hardware performs add-with-carry, subtract-with-borrow, increment, decrement and compare.

A three-bit output select drives a store/transfer bus. Its values include a constant zero for store-zero instructions and the memory operand for plain moves. A three-bit write select names the register that captures the result on the clock edge. When the write select names the status register, the block only raises a strobe, because the status register lives outside the block.

Top module: `acc_alu_core`

## Requirements
- R1: Q operand: qSel 0 selects register A, 1 selects memIn, 2 selects X, 3 selects Y. R operand: rSel 1 gives the constant 1 and rSel 0 gives memIn.
- R2: For opSel 4 (add), 5 (subtract), 6 (increment), 7 (decrement) and 15 (compare):
  - the effective operand R' is ~R when subMode is 1 and R otherwise;
  - the carry-in Ci is subMode when carrySel is 1 and carryFlag otherwise;
  - result is the low byte of Q + R' + Ci, and carryOut is its ninth bit.
- R3: For the five adder operations, overflow is high exactly when Q[7] equals R'[7] and result[7] differs from Q[7]. For every other operation, overflow is 0.
- R4: opSel 1, 2 and 3 give A AND memIn, A OR memIn and A XOR memIn respectively. For these operations carryOut is 0.
- R5: opSel 8 shifts Q left with a 0 fill. opSel 9 shifts Q right with a 0 fill. opSel 10 rotates Q left through carryFlag. opSel 11 rotates Q right through carryFlag. Left forms set carryOut to Q[7]; right forms set carryOut to Q[0].
- R6: opSel 12 (bit test) gives A AND memIn. opSel 13 (test-and-reset) gives memIn AND NOT A. opSel 14 (test-and-set) gives memIn OR A. For all three, carryOut is 0.
- R7: opSel 0 (transfer) sets result to the current outBus value, with carryOut 0.
- R8: outBus is selected by outSel as follows: 1 gives A, 2 gives X, 3 gives Y, 4 gives the constant zero, 5 gives S, 6 gives statusIn, 7 gives memIn, and 0 gives zero.
- R9: On a rising edge with wrEn high, result is written to A, X, Y or S for wrSel 1, 2, 3 or 5. wrSel 0, 4, 6 and 7 write no register, and every register holds while wrEn is low. The statusWe output is high exactly when wrEn is high and wrSel is 6.
- R10: A synchronous reset clears A, X and Y and sets S to 8'hFF. Reset takes priority over any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opSel | input | 4 | Operation code |
| qSel | input | 2 | Q operand select |
| rSel | input | 1 | R operand select (1: constant one) |
| subMode | input | 1 | Adder subtract mode |
| carrySel | input | 1 | Carry-in source select |
| carryFlag | input | 1 | Current carry flag from the status register |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 3 | Destination register select |
| outSel | input | 3 | Output bus select |
| memIn | input | 8 | Memory operand |
| statusIn | input | 8 | Current status byte |
| result | output | 8 | ALU result |
| carryOut | output | 1 | Carry out of the selected operation |
| overflow | output | 1 | Signed overflow of the adder |
| outBus | output | 8 | Store/transfer bus |
| statusWe | output | 1 | Status register write strobe |
| regA | output | 8 | Accumulator |
| regX | output | 8 | X index register |
| regY | output | 8 | Y index register |
| regS | output | 8 | Stack pointer |

## Verification
Several properties are checked on every cycle:
- the register values just after reset;
- that all registers hold when no write is requested;
- that an accumulator write captures the previous result;
- the zero on outBus for the store-zero select;
- the bit-level signatures of test-and-reset and test-and-set against A;
- the absence of carry and overflow on logic operations.

The arithmetic values need the bench's scenarios. These cover carry and overflow at the 7F/80 and FF/00 boundaries, the carry-in steering of increment, decrement and compare, rotates through the carry flag, and write selects that must leave every register untouched.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [3:0] {
    OP_XFR = 4'd0,  OP_AND = 4'd1,  OP_OR  = 4'd2,  OP_XOR = 4'd3,
    OP_ADD = 4'd4,  OP_SUB = 4'd5,  OP_INC = 4'd6,  OP_DEC = 4'd7,
    OP_SHL = 4'd8,  OP_SHR = 4'd9,  OP_ROL = 4'd10, OP_ROR = 4'd11,
    OP_BIT = 4'd12, OP_TRB = 4'd13, OP_TSB = 4'd14, OP_CMP = 4'd15
  } aluOp_e;

  typedef enum logic [1:0] {
    UNIT_MOVE  = 2'd0,
    UNIT_LOGIC = 2'd1,
    UNIT_ADDER = 2'd2,
    UNIT_SHIFT = 2'd3
  } aluUnit_e;

  typedef enum logic [1:0] {
    LF_AND    = 2'd0,
    LF_OR     = 2'd1,
    LF_XOR    = 2'd2,
    LF_ANDNOT = 2'd3
  } logicFn_e;

  localparam int NUM_REGS = 4;
  localparam int IDX_A = 0;
  localparam int IDX_X = 1;
  localparam int IDX_Y = 2;
  localparam int IDX_S = 3;

  localparam logic [2:0] WSEL_STATUS = 3'd6;

  // Write-select code that targets each register-file slot.
  function automatic logic [2:0] wrCodeOf(input int idx);
    case (idx)
      IDX_A:   wrCodeOf = 3'd1;
      IDX_X:   wrCodeOf = 3'd2;
      IDX_Y:   wrCodeOf = 3'd3;
      default: wrCodeOf = 3'd5;
    endcase
  endfunction

  typedef struct packed {
    aluUnit_e              unit;
    logicFn_e              logicFn;
    logic                  shRight;
    logic                  shRotate;
    logic [NUM_REGS-1:0]   regWe;
    logic                  statusWe;
  } ctrlStrobe_t;

endpackage

// File: rtl/acc_alu_ctrl.sv
module acc_alu_ctrl
  import acc_alu_pkg::*;
(
  input  logic [3:0]  opSel,
  input  logic        wrEn,
  input  logic [2:0]  wrSel,
  output ctrlStrobe_t strobe
);

  aluOp_e op;
  assign op = aluOp_e'(opSel);

  // Unit and sub-function decode.
  always_comb begin
    strobe.unit     = UNIT_MOVE;
    strobe.logicFn  = LF_AND;
    strobe.shRight  = 1'b0;
    strobe.shRotate = 1'b0;
    unique case (op)
      OP_XFR: strobe.unit = UNIT_MOVE;
      OP_AND, OP_BIT: begin
        strobe.unit    = UNIT_LOGIC;
        strobe.logicFn = LF_AND;
      end
      OP_OR, OP_TSB: begin
        strobe.unit    = UNIT_LOGIC;
        strobe.logicFn = LF_OR;
      end
      OP_XOR: begin
        strobe.unit    = UNIT_LOGIC;
        strobe.logicFn = LF_XOR;
      end
      OP_TRB: begin
        strobe.unit    = UNIT_LOGIC;
        strobe.logicFn = LF_ANDNOT;
      end
      OP_ADD, OP_SUB, OP_INC, OP_DEC, OP_CMP:
        strobe.unit = UNIT_ADDER;
      OP_SHL: strobe.unit = UNIT_SHIFT;
      OP_SHR: begin
        strobe.unit    = UNIT_SHIFT;
        strobe.shRight = 1'b1;
      end
      OP_ROL: begin
        strobe.unit     = UNIT_SHIFT;
        strobe.shRotate = 1'b1;
      end
      OP_ROR: begin
        strobe.unit     = UNIT_SHIFT;
        strobe.shRight  = 1'b1;
        strobe.shRotate = 1'b1;
      end
      default: strobe.unit = UNIT_MOVE;
    endcase
  end

  // One write enable per register-file slot.
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_we
    assign strobe.regWe[i] = wrEn && (wrSel == wrCodeOf(i));
  end

  assign strobe.statusWe = wrEn && (wrSel == WSEL_STATUS);

endmodule

// File: rtl/acc_alu_datapath.sv
module acc_alu_datapath
  import acc_alu_pkg::*;
#(
  parameter int              DATA_W     = 8,
  parameter logic [DATA_W-1:0] STACK_INIT = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       strobe,
  input  logic [1:0]        qSel,
  input  logic              rSel,
  input  logic              subMode,
  input  logic              carrySel,
  input  logic              carryFlag,
  input  logic [2:0]        outSel,
  input  logic [DATA_W-1:0] memIn,
  input  logic [DATA_W-1:0] statusIn,
  output logic [DATA_W-1:0] result,
  output logic              carryOut,
  output logic              overflow,
  output logic [DATA_W-1:0] outBus,
  output logic [DATA_W-1:0] regA,
  output logic [DATA_W-1:0] regX,
  output logic [DATA_W-1:0] regY,
  output logic [DATA_W-1:0] regS
);

  localparam int MSB = DATA_W - 1;
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] regFile [NUM_REGS];

  assign regA = regFile[IDX_A];
  assign regX = regFile[IDX_X];
  assign regY = regFile[IDX_Y];
  assign regS = regFile[IDX_S];

  // Output bus mux.
  always_comb begin
    case (outSel)
      3'd1:    outBus = regA;
      3'd2:    outBus = regX;
      3'd3:    outBus = regY;
      3'd5:    outBus = regS;
      3'd6:    outBus = statusIn;
      3'd7:    outBus = memIn;
      default: outBus = '0;
    endcase
  end

  // Operand selection.
  logic [DATA_W-1:0] qOpd, rOpd, rEff;
  always_comb begin
    case (qSel)
      2'd0:    qOpd = regA;
      2'd1:    qOpd = memIn;
      2'd2:    qOpd = regX;
      default: qOpd = regY;
    endcase
  end
  assign rOpd = rSel ? ONE : memIn;
  assign rEff = subMode ? ~rOpd : rOpd;

  // Shared adder.
  logic              carryIn;
  logic [DATA_W:0]   sumFull;
  logic              addOvf;
  assign carryIn = carrySel ? subMode : carryFlag;
  assign sumFull = {1'b0, qOpd} + {1'b0, rEff} + {{DATA_W{1'b0}}, carryIn};
  assign addOvf  = (qOpd[MSB] == rEff[MSB]) && (sumFull[MSB] != qOpd[MSB]);

  // Logic and bit-test unit: always accumulator against memory.
  logic [DATA_W-1:0] logicRes;
  always_comb begin
    case (strobe.logicFn)
      LF_AND:    logicRes = regA & memIn;
      LF_OR:     logicRes = regA | memIn;
      LF_XOR:    logicRes = regA ^ memIn;
      default:   logicRes = memIn & ~regA;
    endcase
  end

  // Shift / rotate unit on the Q operand.
  logic              shFill, shCo;
  logic [DATA_W-1:0] shRes;
  assign shFill = strobe.shRotate ? carryFlag : 1'b0;
  assign shRes  = strobe.shRight ? {shFill, qOpd[MSB:1]} : {qOpd[MSB-1:0], shFill};
  assign shCo   = strobe.shRight ? qOpd[0] : qOpd[MSB];

  // Result mux.
  always_comb begin
    result   = outBus;
    carryOut = 1'b0;
    overflow = 1'b0;
    case (strobe.unit)
      UNIT_LOGIC: result = logicRes;
      UNIT_ADDER: begin
        result   = sumFull[MSB:0];
        carryOut = sumFull[DATA_W];
        overflow = addOvf;
      end
      UNIT_SHIFT: begin
        result   = shRes;
        carryOut = shCo;
      end
      default: result = outBus;
    endcase
  end

  // Register file, one slot per generate branch.
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [DATA_W-1:0] RST_VAL = (i == IDX_S) ? STACK_INIT : '0;
    always_ff @(posedge clk) begin
      if (rst)                  regFile[i] <= RST_VAL;
      else if (strobe.regWe[i]) regFile[i] <= result;
    end
  end

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        opSel,
  input  logic [1:0]        qSel,
  input  logic              rSel,
  input  logic              subMode,
  input  logic              carrySel,
  input  logic              carryFlag,
  input  logic              wrEn,
  input  logic [2:0]        wrSel,
  input  logic [2:0]        outSel,
  input  logic [DATA_W-1:0] memIn,
  input  logic [DATA_W-1:0] statusIn,
  output logic [DATA_W-1:0] result,
  output logic              carryOut,
  output logic              overflow,
  output logic [DATA_W-1:0] outBus,
  output logic              statusWe,
  output logic [DATA_W-1:0] regA,
  output logic [DATA_W-1:0] regX,
  output logic [DATA_W-1:0] regY,
  output logic [DATA_W-1:0] regS
);

  ctrlStrobe_t strobe;

  acc_alu_ctrl u_ctrl (
    .opSel  (opSel),
    .wrEn   (wrEn),
    .wrSel  (wrSel),
    .strobe (strobe)
  );

  acc_alu_datapath #(
    .DATA_W     (DATA_W),
    .STACK_INIT ({DATA_W{1'b1}})
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .qSel      (qSel),
    .rSel      (rSel),
    .subMode   (subMode),
    .carrySel  (carrySel),
    .carryFlag (carryFlag),
    .outSel    (outSel),
    .memIn     (memIn),
    .statusIn  (statusIn),
    .result    (result),
    .carryOut  (carryOut),
    .overflow  (overflow),
    .outBus    (outBus),
    .regA      (regA),
    .regX      (regX),
    .regY      (regY),
    .regS      (regS)
  );

  assign statusWe = strobe.statusWe;

endmodule

// File: rtl/acc_alu_checks.sv
module acc_alu_checks #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        opSel,
  input logic              wrEn,
  input logic [2:0]        wrSel,
  input logic [2:0]        outSel,
  input logic [DATA_W-1:0] result,
  input logic              carryOut,
  input logic              overflow,
  input logic [DATA_W-1:0] outBus,
  input logic [DATA_W-1:0] regA,
  input logic [DATA_W-1:0] regX,
  input logic [DATA_W-1:0] regY,
  input logic [DATA_W-1:0] regS
);

  logic pastValid = 1'b0;
  always_ff @(posedge clk) pastValid <= 1'b1;

  // R10: register values right after a reset cycle.
  always @(posedge clk) begin
    if (pastValid && $past(rst)) begin
      a_r10_reset_values: assert (regA == '0 && regX == '0 && regY == '0 && regS == '1)
        else $error("reset values wrong");
    end
  end

  // R9: no write strobe, no register change.
  a_r9_hold_regs: assert property (@(posedge clk) disable iff (rst)
    !wrEn |=> ($stable(regA) && $stable(regX) && $stable(regY) && $stable(regS)));

  // R9: accumulator write captures the result of the previous cycle.
  a_r9_write_acc: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrSel == 3'd1) |=> (regA == $past(result)));

  // R8: store-zero select drives zero.
  a_r8_store_zero: assert property (@(posedge clk) disable iff (rst)
    (outSel == 3'd4) |-> (outBus == '0));

  // R6: test-and-reset leaves no accumulator bit set.
  a_r6_trb_clears: assert property (@(posedge clk) disable iff (rst)
    (opSel == 4'd13) |-> ((result & regA) == '0));

  // R6: test-and-set leaves every accumulator bit set.
  a_r6_tsb_sets: assert property (@(posedge clk) disable iff (rst)
    (opSel == 4'd14) |-> ((result & regA) == regA));

  // R4: logic operations produce neither carry nor overflow.
  a_r4_logic_no_flags: assert property (@(posedge clk) disable iff (rst)
    (opSel >= 4'd1 && opSel <= 4'd3) |-> (!carryOut && !overflow));

endmodule

bind acc_alu_core acc_alu_checks #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_acc_alu_core.sv
`timescale 1ns/100ps
module sim_acc_alu_core;

  localparam int W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst, rSel, subMode, carrySel, carryFlag, wrEn;
  logic [3:0]   opSel;
  logic [1:0]   qSel;
  logic [2:0]   wrSel, outSel;
  logic [W-1:0] memIn, statusIn;
  logic [W-1:0] result, outBus, regA, regX, regY, regS;
  logic         carryOut, overflow, statusWe;

  acc_alu_core #(.DATA_W(W)) u0 (.*);

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [W-1:0] mA, mX, mY, mS;

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [W-1:0] modelBus(input logic [2:0] os);
    case (os)
      3'd1: return mA;
      3'd2: return mX;
      3'd3: return mY;
      3'd5: return mS;
      3'd6: return statusIn;
      3'd7: return memIn;
      default: return '0;
    endcase
  endfunction

  // Returns {overflow, carry, result}.
  function automatic logic [W+1:0] modelAlu();
    logic [W-1:0] q, r, rp, res;
    logic ci, co, ov;
    logic [W:0] s;
    q = (qSel == 0) ? mA : (qSel == 1) ? memIn : (qSel == 2) ? mX : mY;
    r = rSel ? 8'h01 : memIn;
    rp = subMode ? ~r : r;
    ci = carrySel ? subMode : carryFlag;
    co = 1'b0; ov = 1'b0;
    case (opSel)
      4'd1, 4'd12: res = mA & memIn;
      4'd2, 4'd14: res = mA | memIn;
      4'd3:        res = mA ^ memIn;
      4'd13:       res = memIn & ~mA;
      4'd4, 4'd5, 4'd6, 4'd7, 4'd15: begin
        s = q + rp + ci;
        res = s[W-1:0]; co = s[W];
        ov = (q[7] == rp[7]) && (res[7] != q[7]);
      end
      4'd8:  begin res = q << 1;             co = q[7]; end
      4'd9:  begin res = q >> 1;             co = q[0]; end
      4'd10: begin res = {q[6:0], carryFlag}; co = q[7]; end
      4'd11: begin res = {carryFlag, q[7:1]}; co = q[0]; end
      default: res = modelBus(outSel);
    endcase
    return {ov, co, res};
  endfunction

  function automatic string reqOf(input logic [3:0] op);
    case (op)
      4'd0: return "R7";
      4'd1, 4'd2, 4'd3: return "R4";
      4'd8, 4'd9, 4'd10, 4'd11: return "R5";
      4'd12, 4'd13, 4'd14: return "R6";
      default: return "R2";
    endcase
  endfunction

  // Drive one microword, check outputs before the edge and registers after.
  task automatic step(input logic [3:0] op, input logic [1:0] q, input logic rs,
                      input logic sm, input logic cs, input logic cf,
                      input logic we, input logic [2:0] ws, input logic [2:0] os,
                      input logic [W-1:0] m, input logic rr);
    logic [W+1:0] e;
    @(negedge clk);
    opSel = op; qSel = q; rSel = rs; subMode = sm; carrySel = cs; carryFlag = cf;
    wrEn = we; wrSel = ws; outSel = os; memIn = m; rst = rr;
    #0.5;
    e = modelAlu();
    if (!rr) begin
      chk(reqOf(op), "result", result, e[W-1:0]);
      chk((op >= 4 && op <= 7) || op == 15 ? "R2" : reqOf(op), "carryOut", carryOut, e[W]);
      chk("R3", "overflow", overflow, e[W+1]);
      chk("R8", "outBus", outBus, modelBus(os));
      chk("R9", "statusWe", statusWe, we && ws == 3'd6);
    end
    @(posedge clk);
    #1;
    if (rr) begin
      mA = '0; mX = '0; mY = '0; mS = 8'hFF;
    end else if (we) begin
      case (ws)
        3'd1: mA = e[W-1:0];
        3'd2: mX = e[W-1:0];
        3'd3: mY = e[W-1:0];
        3'd5: mS = e[W-1:0];
        default: ;
      endcase
    end
    chk(rr ? "R10" : "R9", "regA", regA, mA);
    chk(rr ? "R10" : "R9", "regX", regX, mX);
    chk(rr ? "R10" : "R9", "regY", regY, mY);
    chk(rr ? "R10" : "R9", "regS", regS, mS);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    statusIn = 8'hA5;
    mA = 'x; mX = 'x; mY = 'x; mS = 'x;
    // R10: reset with a write also requested; reset wins.
    step(4'd0, 0, 0, 0, 0, 0, 1, 3'd1, 3'd7, 8'h3C, 1);
    // Load A=7F, X=FF, S=40 by transfer of memIn (R7).
    step(4'd0, 0, 0, 0, 0, 0, 1, 3'd1, 3'd7, 8'h7F, 0);
    step(4'd0, 0, 0, 0, 0, 0, 1, 3'd2, 3'd7, 8'hFF, 0);
    step(4'd0, 0, 0, 0, 0, 0, 1, 3'd5, 3'd7, 8'h40, 0);
    // R3: 7F + 01 overflows into 80 with no carry.
    @(negedge clk);
    opSel = 4'd4; qSel = 0; rSel = 0; subMode = 0; carrySel = 0; carryFlag = 0;
    wrEn = 0; memIn = 8'h01; #0.5;
    chk("R3", "7F+1 result", result, 8'h80);
    chk("R3", "7F+1 overflow", overflow, 1);
    chk("R2", "7F+1 carry", carryOut, 0);
    // R2: increment X=FF wraps to 00 with carry (Ci from subMode=0).
    opSel = 4'd6; qSel = 2; rSel = 1; carrySel = 1; carryFlag = 1; #0.5;
    chk("R2", "inc FF result", result, 8'h00);
    chk("R2", "inc FF carry", carryOut, 1);
    // R2: compare A with equal memIn gives zero and carry set.
    opSel = 4'd15; qSel = 0; rSel = 0; subMode = 1; carrySel = 1; carryFlag = 0; memIn = 8'h7F; #0.5;
    chk("R2", "cmp eq result", result, 8'h00);
    chk("R2", "cmp eq carry", carryOut, 1);
    // R5: rotate right of 01 through carry=1 gives 80, carry out 1.
    opSel = 4'd11; qSel = 1; subMode = 0; carrySel = 0; carryFlag = 1; memIn = 8'h01; #0.5;
    chk("R5", "ror result", result, 8'h80);
    chk("R5", "ror carry", carryOut, 1);
    // R8: store-zero and status selects.
    outSel = 3'd4; #0.5;
    chk("R8", "store zero", outBus, 8'h00);
    outSel = 3'd6; #0.5;
    chk("R8", "status bus", outBus, 8'hA5);
    // R9: write selects that target no register.
    step(4'd0, 0, 0, 0, 0, 0, 1, 3'd4, 3'd7, 8'h11, 0);
    step(4'd0, 0, 0, 0, 0, 0, 1, 3'd7, 3'd7, 8'h22, 0);
    step(4'd0, 0, 0, 0, 0, 0, 1, 3'd6, 3'd7, 8'h33, 0);
    step(4'd0, 0, 0, 0, 0, 0, 1, 3'd0, 3'd7, 8'h44, 0);
    // R1: each Q source through decrement, into Y.
    for (int i = 0; i < 4; i++)
      step(4'd7, 2'(i), 1, 1, 1, 0, 1, 3'd3, 3'd0, 8'h90, 0);
    // Constrained random mix.
    for (int n = 0; n < 3000; n++) begin
      step(4'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), 3'($urandom), 3'($urandom), 8'($urandom),
           ($urandom % 97) == 0);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule